// File: doc/BRIEF.md
# SIMD High-Narrowing Add/Subtract Unit

This block executes one vector instruction family. It adds or subtracts two 128-bit source registers lane by lane at double width. It can add a round-half-up constant, and it keeps only the upper half of each wide lane result. The narrowed lanes always come to 64 bits. A placement bit chooses where they go. In one mode they fill the low half of the destination and the top half is cleared. In the other mode they fill the top half and the low half keeps the old destination contents.

The unit decodes the 32-bit instruction word itself. The caller supplies the two source operands and the current destination value, and pulses `valid_i`. One clock later the unit returns the new destination value with `valid_o`. If the encoding is not one this unit accepts, it raises `illegal_o` and returns the old destination value unchanged. The caller handles register-file access and any trap.

Top module: `hn_narrow_unit`

## Requirements
- R1: An instruction is accepted only when all of these hold: bit 31 = 0, bits 28:24 = 5'b01110, bit 21 = 1, bits 11:10 = 2'b00, bits 15:12 equal 4'b0100 or 4'b0110, and bits 23:22 are not 2'b11. Any other word sets `illegal_o` and returns `dest_i` unchanged as `dest_o`. Bits 20:16, 9:5 and 4:0 (register numbers) have no effect on the result.
- R2: Opcode 4'b0100 selects wide addition, src_a lane + src_b lane.
- R3: Opcode 4'b0110 selects wide subtraction, src_a lane − src_b lane.
- R4: Bit 29 = 1 adds 1 << (E−1) to each wide result before the high half is taken. E is the narrow element width.
- R5: Size bits 23:22 = 0, 1, 2 give E = 8, 16, 32 and source lanes of 2E bits. There are 8, 4 and 2 lanes, and narrow lane i is bits [2E−1:E] of wide lane i.
- R6: Wide arithmetic, including the rounding add, wraps modulo 2^(2E). Carries and borrows out of a lane are discarded and do not reach a neighbouring lane.
- R7: With bit 30 (Q) = 0, narrow lane i goes to dest_o[i*E +: E] and dest_o[127:64] is zero.
- R8: With Q = 1, narrow lane i goes to dest_o[64 + i*E +: E] and dest_o[63:0] equals dest_i[63:0].
- R9: Size 2'b11 with otherwise valid fields is illegal (R1 behaviour).
- R10: `valid_o` and `illegal_o` follow `valid_i` by one clock. Outputs reset to zero. While `valid_i` is low, `dest_o` holds its value and `illegal_o` and `valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| instr_i | input | 32 | Instruction word |
| src_a_i | input | 128 | First source operand |
| src_b_i | input | 128 | Second source operand |
| dest_i | input | 128 | Current destination value |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| dest_o | output | 128 | New destination value |
| illegal_o | output | 1 | Encoding rejected |

## Verification
Random legal words cover every combination of opcode, rounding, size and Q, using random operands and random register fields. A wrong lane width, opcode sense, rounding constant or half placement therefore shows up as a mismatch against the bench model. Directed all-ones and zero-minus-one operands separate correct per-lane wrap from carry or borrow leaking into the next lane. The rounding case with the low half at exactly 1 << (E−1) separates round-half-up from truncation. Corrupted fixed bits, stray opcodes and size 3 show that illegal words leave the destination untouched. Idle cycles show that the registered result holds.

// File: rtl/hn_pkg.sv
package hn_pkg;
  localparam int unsigned VLEN     = 128;
  localparam int unsigned HLEN     = VLEN / 2;
  localparam int unsigned EMIN     = 8;
  localparam int unsigned NUM_SIZE = 3;
  localparam int unsigned SZW      = 2;

  localparam logic [3:0] OPC_ADD = 4'b0100;
  localparam logic [3:0] OPC_SUB = 4'b0110;
  localparam logic [4:0] GRP_ID  = 5'b01110;

  typedef struct packed {
    logic           legal;
    logic           sub;
    logic           rnd;
    logic           upper;
    logic [SZW-1:0] size;
  } hn_op_t;
endpackage

// File: rtl/hn_decode.sv
module hn_decode
  import hn_pkg::*;
(
  input  logic [31:0] instr_i,
  output hn_op_t      op_o
);
  logic fixed_ok, opc_ok, size_ok;

  assign fixed_ok = (instr_i[31] == 1'b0) && (instr_i[28:24] == GRP_ID) &&
                    instr_i[21] && (instr_i[11:10] == 2'b00);
  assign opc_ok   = (instr_i[15:12] == OPC_ADD) || (instr_i[15:12] == OPC_SUB);
  assign size_ok  = 32'(instr_i[23:22]) < NUM_SIZE;

  always_comb begin
    op_o.legal = fixed_ok && opc_ok && size_ok;
    op_o.sub   = (instr_i[15:12] == OPC_SUB);
    op_o.rnd   = instr_i[29];
    op_o.upper = instr_i[30];
    op_o.size  = instr_i[23:22];
  end
endmodule

// File: rtl/hn_lanes.sv
module hn_lanes
  import hn_pkg::*;
#(
  parameter int unsigned W_VEC = VLEN,
  parameter int unsigned E_MIN = EMIN,
  parameter int unsigned N_SZ  = NUM_SIZE
) (
  input  logic [W_VEC-1:0]   a_i,
  input  logic [W_VEC-1:0]   b_i,
  input  logic               sub_i,
  input  logic               rnd_i,
  input  logic [SZW-1:0]     size_i,
  output logic [W_VEC/2-1:0] narrow_o
);
  localparam int unsigned W_HALF = W_VEC / 2;

  logic [N_SZ-1:0][W_HALF-1:0] res;

  for (genvar s = 0; s < N_SZ; s++) begin : g_size
    localparam int unsigned E     = E_MIN << s;
    localparam int unsigned W     = 2 * E;
    localparam int unsigned LANES = W_HALF / E;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [W-1:0] op_b, rc, wide;
      assign op_b = sub_i ? ~b_i[l*W +: W] : b_i[l*W +: W];
      assign rc   = rnd_i ? (W'(1) << (E - 1)) : '0;
      // two's complement subtract: a + ~b + 1; all sums wrap at W bits
      assign wide = a_i[l*W +: W] + op_b + W'(sub_i) + rc;
      assign res[s][l*E +: E] = wide[W-1:E];
    end
  end

  always_comb begin
    narrow_o = '0;
    for (int s = 0; s < N_SZ; s++)
      if (32'(size_i) == s) narrow_o = res[s];
  end
endmodule

// File: rtl/hn_place.sv
module hn_place
  import hn_pkg::*;
#(
  parameter int unsigned W_VEC = VLEN
) (
  input  logic [W_VEC-1:0]   dest_i,
  input  logic [W_VEC/2-1:0] narrow_i,
  input  logic               upper_i,
  input  logic               legal_i,
  output logic [W_VEC-1:0]   dest_o
);
  always_comb begin
    if (!legal_i)     dest_o = dest_i;
    else if (upper_i) dest_o = {narrow_i, dest_i[W_VEC/2-1:0]};
    else              dest_o = {{(W_VEC/2){1'b0}}, narrow_i};
  end
endmodule

// File: rtl/hn_narrow_unit.sv
module hn_narrow_unit
  import hn_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [31:0]      instr_i,
  input  logic [VLEN-1:0]  src_a_i,
  input  logic [VLEN-1:0]  src_b_i,
  input  logic [VLEN-1:0]  dest_i,
  output logic             valid_o,
  output logic [VLEN-1:0]  dest_o,
  output logic             illegal_o
);
  hn_op_t            op;
  logic [HLEN-1:0]   narrow;
  logic [VLEN-1:0]   dest_nxt;

  hn_decode i_dec (.instr_i(instr_i), .op_o(op));

  hn_lanes #(.W_VEC(VLEN), .E_MIN(EMIN), .N_SZ(NUM_SIZE)) i_lanes (
    .a_i(src_a_i), .b_i(src_b_i), .sub_i(op.sub), .rnd_i(op.rnd),
    .size_i(op.size), .narrow_o(narrow)
  );

  hn_place #(.W_VEC(VLEN)) i_place (
    .dest_i(dest_i), .narrow_i(narrow), .upper_i(op.upper),
    .legal_i(op.legal), .dest_o(dest_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      dest_o    <= '0;
    end else begin
      valid_o   <= valid_i;
      illegal_o <= valid_i && !op.legal;
      if (valid_i) dest_o <= dest_nxt;
    end
  end

  // R10
  a_r10_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !illegal_o && $stable(dest_o)));
  // R1
  a_r1_bad_opcode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[15:12] != OPC_ADD && instr_i[15:12] != OPC_SUB)
    |=> (illegal_o && dest_o == $past(dest_i)));
  // R9
  a_r9_size3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[23:22] == 2'b11) |=> (illegal_o && dest_o == $past(dest_i)));
  // R7
  a_r7_top_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op.legal && !instr_i[30]) |=> (dest_o[VLEN-1:HLEN] == '0));
  // R8
  a_r8_low_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op.legal && instr_i[30]) |=> (dest_o[HLEN-1:0] == $past(dest_i[HLEN-1:0])));
endmodule

// File: tb/test_hn_narrow_unit.sv
module test_hn_narrow_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [31:0]  instr_i = '0;
  logic [127:0] src_a_i = '0, src_b_i = '0, dest_i = '0;
  logic         valid_o, illegal_o;
  logic [127:0] dest_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #4 clk_i = ~clk_i;

  hn_narrow_unit i_hn_narrow_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .dest_i(dest_i),
    .valid_o(valid_o), .dest_o(dest_o), .illegal_o(illegal_o)
  );

  function automatic logic [31:0] mk(bit q, bit u, logic [1:0] sz, logic [3:0] opc);
    return {1'b0, q, u, 5'b01110, sz, 1'b1, 5'($urandom), opc, 2'b00,
            5'($urandom), 5'($urandom)};
  endfunction

  function automatic bit is_legal(logic [31:0] w);
    return w[31] == 0 && w[28:24] == 5'b01110 && w[21] && w[11:10] == 0 &&
           (w[15:12] == 4'b0100 || w[15:12] == 4'b0110) && w[23:22] != 2'b11;
  endfunction

  function automatic logic [127:0] model(logic [31:0] w, logic [127:0] a,
                                         logic [127:0] b, logic [127:0] d);
    int e, lanes;
    logic [127:0] m2, wa, wb, r, nar;
    if (!is_legal(w)) return d;
    e = 8 << w[23:22];
    lanes = 64 / e;
    m2 = (128'd1 << (2 * e)) - 1;
    nar = '0;
    for (int i = 0; i < lanes; i++) begin
      wa = (a >> (i * 2 * e)) & m2;
      wb = (b >> (i * 2 * e)) & m2;
      r  = (w[15:12] == 4'b0110) ? wa - wb : wa + wb;
      if (w[29]) r = r + (128'd1 << (e - 1));
      r = (r & m2) >> e;
      nar = nar | (r << (i * e));
    end
    return w[30] ? {nar[63:0], d[63:0]} : {64'd0, nar[63:0]};
  endfunction

  task automatic check(string tag, logic [127:0] got, logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(string tag, logic [31:0] w, logic [127:0] a,
                     logic [127:0] b, logic [127:0] d);
    logic [127:0] exp;
    exp = model(w, a, b, d);
    instr_i = w; src_a_i = a; src_b_i = b; dest_i = d; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({tag, " dest"}, dest_o, exp);
    check("R10 valid", 128'(valid_o), 128'd1);
    check({tag, " illegal"}, 128'(illegal_o), 128'(!is_legal(w)));
  endtask

  function automatic logic [127:0] r128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    check("R10 reset dest", dest_o, '0);
    check("R10 reset valid", 128'({valid_o, illegal_o}), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5 one per size, simple increasing lanes
    for (int s = 0; s < 3; s++)
      run("R5 size", mk(0, 0, 2'(s), 4'b0100),
          128'h0f0e_0d0c_0b0a_0908_0706_0504_0302_0100, 128'h0100_0100_0100_0100_0100_0100_0100_0100, '1);
    // R6 all-ones add: wrap per lane
    run("R6 wrap add", mk(0, 1, 2'd0, 4'b0100), '1, '1, r128());
    run("R6 wrap add32", mk(1, 1, 2'd2, 4'b0100), '1, '1, r128());
    // R6 borrow 0-1
    run("R6 borrow", mk(0, 0, 2'd1, 4'b0110), '0, {8{16'h0001}}, r128());
    // R4 exact half rounds up; R2 without rounding truncates
    run("R4 round half", mk(0, 1, 2'd0, 4'b0100), {8{16'h0070}}, {8{16'h0010}}, '0);
    run("R2 no round", mk(0, 0, 2'd0, 4'b0100), {8{16'h0070}}, {8{16'h0010}}, '0);
    // R3 sub order
    run("R3 sub order", mk(0, 0, 2'd2, 4'b0110), {2{64'h5_0000_0000}}, {2{64'h3_0000_0000}}, '0);
    // R7 / R8 placement
    run("R7 low half", mk(0, 0, 2'd1, 4'b0100), r128(), r128(), '1);
    run("R8 high half", mk(1, 0, 2'd1, 4'b0100), r128(), r128(), 128'h1234_5678_9abc_def0_0fed_cba9_8765_4321);
    // R9 size 3, R1 bad fields
    run("R9 size3", mk(0, 0, 2'd3, 4'b0100), r128(), r128(), r128());
    run("R1 bad opcode", mk(0, 0, 2'd0, 4'b0101), r128(), r128(), r128());
    run("R1 bit31", mk(0, 0, 2'd0, 4'b0100) | 32'h8000_0000, r128(), r128(), r128());
    run("R1 bit21", mk(1, 0, 2'd1, 4'b0110) & ~32'h0020_0000, r128(), r128(), r128());
    run("R1 bits11_10", mk(0, 1, 2'd2, 4'b0100) | 32'h0000_0400, r128(), r128(), r128());

    // R10 idle hold
    held = dest_o;
    instr_i = mk(0, 0, 2'd0, 4'b0100); src_a_i = r128(); dest_i = r128();
    @(negedge clk_i);
    check("R10 idle dest", dest_o, held);
    check("R10 idle strobes", 128'({valid_o, illegal_o}), '0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      string tag;
      w = mk(1'($urandom), 1'($urandom), 2'($urandom_range(0, 2)),
             ($urandom_range(0, 1) != 0) ? 4'b0110 : 4'b0100);
      if ($urandom_range(0, 9) == 0) w = $urandom;
      tag = !is_legal(w) ? "R1 random" : (w[15:12] == 4'b0110 ? "R3 random" : "R2 random");
      run(tag, w, r128(), r128(), r128());
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule